// File: doc/BRIEF.md
# Low-Power Infrared Pulse Timer

This block derives a slow timing strobe from the reference clock and uses it to shape the infrared signal of a serial infrared link in its low-power mode. An 8-bit divisor sets the strobe period in reference-clock cycles. For a 1.8 MHz nominal strobe, choose the divisor so that the strobe stays between 1.42 MHz and 2.12 MHz. A transmitted zero bit then becomes a light pulse of three strobe periods, about 1.4 to 2.1 µs long. This pulse width does not depend on the baud rate.

On the receive side the infrared line passes through a two-flop synchronizer. The line is reported as active only after it has stayed active for one whole strobe period, so glitches shorter than that period are dropped. The surrounding serial engine marks each bit boundary with a one-cycle `bit_start` strobe and presents the bit on `tx_bit`. The engine also selects low-power operation and supplies the divisor.

Top module: `irlp_timing`

## Requirements
- R1: While `rst` is high at a clock edge, `ir_tx` and `rx_clean` are low after that edge, and the strobe counter is cleared.
- R2: When `lp_en` is low at an edge, `ir_tx` and `rx_clean` are low after it. A `bit_start` seen in that state starts no pulse.
- R3: A divisor of zero yields no strobes. At an edge where `lp_div` is zero, `ir_tx` and `rx_clean` are forced low, and any running pulse is abandoned.
- R4: At an edge where `bit_start` is high, `tx_bit` is 0, the pulser is idle and `lp_div` is D (non-zero), `ir_tx` goes high. It stays high for exactly 3·D cycles, because the strobe phase restarts at the start of the pulse. `ir_tx` is high (1) for light on.
- R5: When `tx_bit` is 1 at a `bit_start`, no pulse is produced.
- R6: A `bit_start` with a zero bit while a pulse is running is ignored. This includes the edge on which the third strobe ends the pulse. The running pulse still ends on schedule.
- R7: `rx_ir` is active-high. Count as edge 1 the first rising edge at which `rx_ir` is sampled high. If `rx_ir` stays high through edges 1..D, `rx_clean` goes high at edge D+2. A shorter pulse never raises `rx_clean`.
- R8: Count as edge 1 the first edge at which `rx_ir` is sampled low. `rx_clean` falls at edge 3. A pulse held for L ≥ D edges therefore gives L−D+1 cycles of `rx_clean`.
- R9: The strobe fires once every D cycles. The counter re-reads `lp_div` at each reload, so a new divisor takes effect from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_div | input | 8 | Low-power strobe divisor, 0 stops the strobe |
| lp_en | input | 1 | Low-power mode select |
| bit_start | input | 1 | One-cycle marker at the start of each transmit bit |
| tx_bit | input | 1 | Serial transmit bit, valid with `bit_start` |
| rx_ir | input | 1 | Raw infrared receive line, active high |
| ir_tx | output | 1 | Shaped infrared transmit pulse |
| rx_clean | output | 1 | Glitch-screened receive pulse |

## Verification
The end of a pulse and the start of the next zero bit can fall on the same edge. The bench provokes this by choosing a bit period of exactly 3·D cycles, so that a new `bit_start` lands on the third strobe. A shorter period places the new bit inside a running pulse. The cycle-exact reference model must see `ir_tx` fall with no retrigger. The bench also counts pulses and measures their widths, to confirm that only the bits arriving to an idle pulser produce light.

// File: rtl/irlp_pkg.sv
package irlp_pkg;

    localparam int PULSE_TICKS = 3;
    localparam int TICK_CNT_W  = $clog2(PULSE_TICKS + 1);

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_PULSE = 1'b1
    } tx_state_e;

    typedef struct packed {
        tx_state_e              st;
        logic [TICK_CNT_W-1:0]  ticks;
    } tx_state_t;

    localparam tx_state_t TX_RESET = '{st: TX_IDLE, ticks: '0};

endpackage

// File: rtl/irlp_tick.sv
module irlp_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            cnt_q <= '0;
        end else if (restart || cnt_q <= ONE) begin
            cnt_q <= div;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign tick = live && (cnt_q == ONE);

endmodule

// File: rtl/irlp_tx_shaper.sv
module irlp_tx_shaper
    import irlp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic tick,
    input  logic bit_start,
    input  logic tx_bit,
    output logic start,
    output logic ir_tx
);
    localparam logic [TICK_CNT_W-1:0] LAST_TICK = TICK_CNT_W'(PULSE_TICKS - 1);

    tx_state_t st_q;

    assign start = live && bit_start && !tx_bit && (st_q.st == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            st_q <= TX_RESET;
        end else if (start) begin
            st_q <= '{st: TX_PULSE, ticks: '0};
        end else if (st_q.st == TX_PULSE && tick) begin
            if (st_q.ticks == LAST_TICK) begin
                st_q <= TX_RESET;
            end else begin
                st_q.ticks <= st_q.ticks + TICK_CNT_W'(1);
            end
        end
    end

    assign ir_tx = (st_q.st == TX_PULSE);

endmodule

// File: rtl/irlp_rx_filter.sv
module irlp_rx_filter #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    input  logic [DIV_W-1:0] div,
    input  logic             rx_in,
    output logic             rx_clean
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [DIV_W-1:0]       run_q;
    logic [DIV_W-1:0]       run_nxt;
    logic                   line_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
        end
    end

    assign line_act = sync_q[SYNC_STAGES-1];
    assign run_nxt  = (run_q == '1) ? run_q : run_q + DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !live || !line_act) begin
            run_q    <= '0;
            rx_clean <= 1'b0;
        end else begin
            run_q    <= run_nxt;
            rx_clean <= (run_nxt >= div);
        end
    end

endmodule

// File: rtl/irlp_timing.sv
module irlp_timing #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] lp_div,
    input  logic             lp_en,
    input  logic             bit_start,
    input  logic             tx_bit,
    input  logic             rx_ir,
    output logic             ir_tx,
    output logic             rx_clean
);
    logic live_w;
    logic tick_w;
    logic start_w;

    assign live_w = lp_en && (lp_div != '0);

    irlp_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .live    (live_w),
        .div     (lp_div),
        .restart (start_w),
        .tick    (tick_w)
    );

    irlp_tx_shaper u_tx (
        .clk       (clk),
        .rst       (rst),
        .live      (live_w),
        .tick      (tick_w),
        .bit_start (bit_start),
        .tx_bit    (tx_bit),
        .start     (start_w),
        .ir_tx     (ir_tx)
    );

    irlp_rx_filter #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .live     (live_w),
        .div      (lp_div),
        .rx_in    (rx_ir),
        .rx_clean (rx_clean)
    );

endmodule

// File: rtl/irlp_timing_chk.sv
module irlp_timing_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] lp_div,
    input logic             lp_en,
    input logic             bit_start,
    input logic             tx_bit,
    input logic             rx_ir,
    input logic             ir_tx,
    input logic             rx_clean,
    input logic             tick
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ir_tx && !rx_clean));

    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !lp_en |=> (!ir_tx && !rx_clean));

    a_r3_zero_div: assert property (@(posedge clk) disable iff (rst)
        (lp_div == '0) |=> (!ir_tx && !rx_clean));

    a_r4_rise_on_zero_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(ir_tx) |-> $past(bit_start && !tx_bit));

    a_r4_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($fell(ir_tx) && $past(lp_en) && $past(lp_div) != '0) |-> $past(tick));

    a_r5_one_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (!ir_tx && bit_start && tx_bit) |=> !ir_tx);

    a_r6_no_cut: assert property (@(posedge clk) disable iff (rst)
        (ir_tx && !tick && lp_en && lp_div != '0) |=> ir_tx);

    a_r7_rise_needs_line: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_clean) |-> $past(rx_ir, 3));

    a_r8_drop: assert property (@(posedge clk) disable iff (rst)
        (!rx_ir && $past(!rx_ir) && $past(!rx_ir, 2)) |=> !rx_clean);

endmodule

bind irlp_timing irlp_timing_chk #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lp_div    (lp_div),
    .lp_en     (lp_en),
    .bit_start (bit_start),
    .tx_bit    (tx_bit),
    .rx_ir     (rx_ir),
    .ir_tx     (ir_tx),
    .rx_clean  (rx_clean),
    .tick      (tick_w)
);

// File: tb/irlp_timing_tb_top.sv
module irlp_timing_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] lp_div = 8'd0;
    logic       lp_en = 1'b0;
    logic       bit_start = 1'b0;
    logic       tx_bit = 1'b1;
    logic       rx_ir = 1'b0;
    logic       ir_tx;
    logic       rx_clean;

    int vecs = 0;
    int fails = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_busy = 0, m_tk = 0;
    int m_s1 = 0, m_s2 = 0, m_rc = 0, m_clean = 0;

    // monitors
    int hi_run = 0, last_width = 0, npulse = 0, clean_cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irlp_timing dut_i (
        .clk(clk), .rst(rst), .lp_div(lp_div), .lp_en(lp_en),
        .bit_start(bit_start), .tx_bit(tx_bit), .rx_ir(rx_ir),
        .ir_tx(ir_tx), .rx_clean(rx_clean)
    );

    always @(posedge clk) begin
        int valid, tick_now, start, old_s2;
        if (rst) begin
            m_cnt = 0; m_busy = 0; m_tk = 0;
            m_s1 = 0; m_s2 = 0; m_rc = 0; m_clean = 0;
        end else begin
            valid    = (lp_en && lp_div != 0) ? 1 : 0;
            tick_now = (valid != 0 && m_cnt == 1) ? 1 : 0;
            start    = (valid != 0 && bit_start && !tx_bit && m_busy == 0) ? 1 : 0;
            if (valid == 0) begin
                m_busy = 0; m_tk = 0;
            end else if (start != 0) begin
                m_busy = 1; m_tk = 0;
            end else if (m_busy != 0 && tick_now != 0) begin
                if (m_tk == 2) begin m_busy = 0; m_tk = 0; end
                else m_tk = m_tk + 1;
            end
            if (valid == 0) m_cnt = 0;
            else if (start != 0 || m_cnt <= 1) m_cnt = lp_div;
            else m_cnt = m_cnt - 1;
            old_s2 = m_s2;
            m_s2 = m_s1;
            m_s1 = rx_ir ? 1 : 0;
            if (valid == 0 || old_s2 == 0) begin
                m_rc = 0; m_clean = 0;
            end else begin
                if (m_rc < 255) m_rc = m_rc + 1;
                m_clean = (m_rc >= lp_div) ? 1 : 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vecs++;
            if (ir_tx !== m_busy[0] || rx_clean !== m_clean[0]) begin
                fails++;
                $display("FAIL %s: ir_tx/rx_clean actual %b/%b expected %0d/%0d at %0t",
                         cur_req, ir_tx, rx_clean, m_busy, m_clean, $time);
            end
            if (ir_tx === 1'b1) hi_run++;
            else if (hi_run > 0) begin
                last_width = hi_run; hi_run = 0; npulse++;
            end
            if (rx_clean === 1'b1) clean_cycles++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b, input int per);
        bit_start = 1'b1; tx_bit = b;
        @(negedge clk);
        bit_start = 1'b0; tx_bit = 1'b1;
        repeat (per - 1) @(negedge clk);
    endtask

    task automatic rx_pulse(input int len);
        rx_ir = 1'b1;
        repeat (len) @(negedge clk);
        rx_ir = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int p0, c0;
        wait_cyc(3);
        cur_req = "R1";
        chk("R1", int'(ir_tx), 0);
        chk("R1", int'(rx_clean), 0);
        rst = 1'b0;

        // R2: mode off
        cur_req = "R2";
        lp_div = 8'd5;
        p0 = npulse; c0 = clean_cycles;
        send_bit(1'b0, 20);
        rx_pulse(15);
        chk("R2", npulse - p0, 0);
        chk("R2", clean_cycles - c0, 0);

        // R3: zero divisor
        cur_req = "R3";
        lp_en = 1'b1; lp_div = 8'd0;
        p0 = npulse; c0 = clean_cycles;
        send_bit(1'b0, 20);
        rx_pulse(15);
        chk("R3", npulse - p0, 0);
        chk("R3", clean_cycles - c0, 0);

        // R4 / R5: widths and one bits
        cur_req = "R4";
        lp_div = 8'd4;
        p0 = npulse;
        send_bit(1'b0, 20);
        chk("R4", last_width, 12);
        cur_req = "R5";
        send_bit(1'b1, 20);
        send_bit(1'b1, 20);
        chk("R5", npulse - p0, 1);
        cur_req = "R4";
        send_bit(1'b0, 20);
        send_bit(1'b0, 20);
        chk("R4", npulse - p0, 3);
        lp_div = 8'd1;
        send_bit(1'b0, 10);
        chk("R4", last_width, 3);

        // R6: collision on the ending edge and overlap
        cur_req = "R6";
        lp_div = 8'd4;
        p0 = npulse;
        send_bit(1'b0, 12);
        send_bit(1'b0, 20);
        chk("R6", npulse - p0, 1);
        chk("R6", last_width, 12);
        p0 = npulse;
        send_bit(1'b0, 8);
        send_bit(1'b0, 8);
        send_bit(1'b0, 20);
        chk("R6", npulse - p0, 2);
        chk("R6", last_width, 12);

        // R3: abort running pulse
        cur_req = "R3";
        send_bit(1'b0, 5);
        lp_div = 8'd0;
        @(negedge clk);
        chk("R3", int'(ir_tx), 0);
        wait_cyc(10);

        // R7 / R8: receive screening
        cur_req = "R7";
        lp_div = 8'd6;
        wait_cyc(3);
        c0 = clean_cycles;
        rx_pulse(3);
        rx_pulse(5);
        chk("R7", clean_cycles - c0, 0);
        cur_req = "R8";
        c0 = clean_cycles;
        rx_pulse(6);
        chk("R8", clean_cycles - c0, 1);
        c0 = clean_cycles;
        rx_pulse(10);
        chk("R8", clean_cycles - c0, 5);

        // R9: divisor changes, including during pulses and receive
        cur_req = "R9";
        lp_div = 8'd3;
        wait_cyc(7);
        send_bit(1'b0, 4);
        lp_div = 8'd7;
        wait_cyc(30);
        lp_div = 8'd5;
        send_bit(1'b0, 20);
        chk("R9", last_width, 15);
        fork
            send_bit(1'b0, 9);
            rx_pulse(9);
        join
        lp_div = 8'd2;
        send_bit(1'b0, 3);
        lp_div = 8'd9;
        wait_cyc(40);
        lp_en = 1'b0;
        wait_cyc(5);
        finish_run();
    end

endmodule